// File: doc/BRIEF.md
# Dual-Channel Register Access Decoder

This block connects a host parallel bus to two identical banks of serial-channel configuration registers, called channel A and channel B. An active-low chip select qualifies every host access. A channel-select input then steers a read or write to one of the two banks. Each bank holds twelve independent byte-wide registers. The banks are plain storage here, and nothing downstream of them is modelled.

A single shared control register sits at its own address, outside both banks. Bit 0 of this register is the broadcast flag. While the flag is set, a host write to any bank register stores the same byte at the same index in both banks on the same clock edge. This lets software set up both channels with one pass of writes. Reads are never broadcast: they always return the register of the bank named by channel select. Writes are registered on the rising clock edge. Read data is combinational from the addressed storage.

Top module: `dual_bank_regport`

## Requirements
- R1: After synchronous reset, every register in both banks and the shared control register reads 0, so broadcast is off.
- R2: While `cs_n` is high, writes change no register, and `rdata` is 0.
- R3: With `cs_n` low and `bank_sel` = 1, an access to addresses 0 to 11 reaches channel A.
- R4: With `cs_n` low and `bank_sel` = 0, an access to addresses 0 to 11 reaches channel B.
- R5: Each bank holds twelve registers at addresses 0 to 11. A write to one register of one bank leaves every other register of either bank unchanged.
- R6: Address 12 selects the shared control register. A write there updates only that register, whatever `bank_sel` is, and a read there returns it for either value of `bank_sel`.
- R7: While control bit 0 is 1, a write to addresses 0 to 11 stores `wdata` at that index in both banks on the same edge, whatever `bank_sel` is.
- R8: While control bit 0 is 1, a read of addresses 0 to 11 still returns only the register of the bank chosen by `bank_sel`.
- R9: Addresses 13 to 15 are unmapped. Writes there change nothing, and reads return 0.
- R10: `rdata` is 0 whenever `rd_en` is low. When `rd_en` is high, `rdata` shows the addressed register in the same cycle. A write becomes visible to reads after the rising edge at which `wr_en` was sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| bank_sel | input | 1 | Channel select: 1 picks channel A, 0 picks channel B |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when nothing is being read |

## Verification
The bench first writes a different pattern into each bank and reads both banks back. A decoder with the channel-select polarity reversed, or with the two banks aliased to each other, returns the other bank's bytes. It then turns broadcast on while `bank_sel` is low and checks that a write reaches both banks. A design that only follows `bank_sel` leaves one bank stale. It also checks that reads still follow `bank_sel`, so a design that broadcasts reads as well returns the wrong bank. Finally, it writes the control register and the unmapped addresses with broadcast on, and it writes while `cs_n` is high. A design that lets such a write leak into a bank, or that drives `rdata` while deselected, is caught on the next read-back.

// File: rtl/rp_pkg.sv
package rp_pkg;
    localparam int DATA_W        = 8;
    localparam int ADDR_W        = 4;
    localparam int REGS_PER_BANK = 12;
    localparam int NUM_BANKS     = 2;
    localparam int BCAST_BIT     = 0;
    localparam int BANK_A        = 0;
    localparam int BANK_B        = 1;
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(REGS_PER_BANK);

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_BANK = 2'd1,
        TGT_CTL  = 2'd2
    } target_e;

    typedef struct packed {
        target_e tgt;
        addr_t   idx;
        logic    to_a;
    } route_t;

    function automatic route_t classify(logic cs_n, logic sel, addr_t a);
        route_t r;
        r.idx  = a;
        r.to_a = sel;
        if (cs_n)
            r.tgt = TGT_NONE;
        else if (int'(a) < REGS_PER_BANK)
            r.tgt = TGT_BANK;
        else if (a == CTL_ADDR)
            r.tgt = TGT_CTL;
        else
            r.tgt = TGT_NONE;
        return r;
    endfunction
endpackage

// File: rtl/rp_decode.sv
module rp_decode
    import rp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n,
    input  logic                 bank_sel,
    input  addr_t                addr,
    input  logic                 wr_en,
    input  logic                 bcast,
    output logic [NUM_BANKS-1:0] bank_we,
    output logic                 ctl_we,
    output route_t               route
);
    always_comb begin
        route   = classify(cs_n, bank_sel, addr);
        bank_we = '0;
        ctl_we  = 1'b0;
        if (wr_en) begin
            unique case (route.tgt)
                TGT_BANK: begin
                    if (bcast)
                        bank_we = '1;
                    else if (route.to_a)
                        bank_we[BANK_A] = 1'b1;
                    else
                        bank_we[BANK_B] = 1'b1;
                end
                TGT_CTL:  ctl_we = 1'b1;
                default:  ;
            endcase
        end
    end

    // R2
    no_write_deselected_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (bank_we == '0 && !ctl_we));

    // R3
    single_target_chk: assert property (@(posedge clk) disable iff (rst)
        !bcast |-> $onehot0({bank_we, ctl_we}));

    // R6
    ctl_private_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_we |-> (bank_we == '0));

    // R9
    unmapped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && int'(addr) > REGS_PER_BANK) |-> (bank_we == '0 && !ctl_we));
endmodule

// File: rtl/rp_bank.sv
module rp_bank
    import rp_pkg::*;
#(
    parameter int DEPTH = REGS_PER_BANK
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  addr_t idx,
    input  data_t wd,
    output data_t rd
);
    data_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we && int'(idx) < DEPTH) begin
            mem[idx] <= wd;
        end
    end

    always_comb begin
        rd = '0;
        for (int i = 0; i < DEPTH; i++)
            if (int'(idx) == i) rd = mem[i];
    end

    // R10
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (we && int'(idx) < DEPTH) |=> (($past(idx) != idx) || rd == $past(wd)));
endmodule

// File: rtl/rp_ctl_reg.sv
module rp_ctl_reg
    import rp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  data_t wd,
    output data_t q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= wd;
    end

    // R6
    ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));
endmodule

// File: rtl/dual_bank_regport.sv
module dual_bank_regport
    import rp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       bank_sel,
    input  logic [3:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);
    logic [NUM_BANKS-1:0] bank_we;
    logic                 ctl_we;
    route_t               route;
    data_t                ctl_q;
    data_t                bank_rd [NUM_BANKS];

    rp_decode u_decode (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .bank_sel (bank_sel),
        .addr     (addr),
        .wr_en    (wr_en),
        .bcast    (ctl_q[BCAST_BIT]),
        .bank_we  (bank_we),
        .ctl_we   (ctl_we),
        .route    (route)
    );

    rp_ctl_reg u_ctl (
        .clk (clk),
        .rst (rst),
        .we  (ctl_we),
        .wd  (wdata),
        .q   (ctl_q)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        rp_bank #(.DEPTH(REGS_PER_BANK)) u_bank (
            .clk (clk),
            .rst (rst),
            .we  (bank_we[b]),
            .idx (route.idx),
            .wd  (wdata),
            .rd  (bank_rd[b])
        );
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (route.tgt)
                TGT_BANK: rdata = route.to_a ? bank_rd[BANK_A] : bank_rd[BANK_B];
                TGT_CTL:  rdata = ctl_q;
                default:  rdata = '0;
            endcase
        end
    end

    // R7
    bcast_both_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q[BCAST_BIT] && wr_en && !cs_n && int'(addr) < REGS_PER_BANK)
            |-> (bank_we == '1));

    // R10
    idle_read_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rdata == '0));

    // R2
    deselect_read_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (rdata == '0));

    // R6
    ctl_update_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !cs_n && addr == CTL_ADDR) |=> (ctl_q == $past(wdata)));
endmodule

// File: tb/dual_bank_regport_test.sv
`timescale 1ns/1ps
module dual_bank_regport_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       bank_sel = 1'b0;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] mdl_a [12];
    logic [7:0] mdl_b [12];
    logic [7:0] mdl_ctl;

    always #2.5 clk = ~clk;

    dual_bank_regport uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .bank_sel(bank_sel), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [7:0] expect_rd();
        if (cs_n || !rd_en) return 8'h00;
        if (addr < 12) return bank_sel ? mdl_a[addr] : mdl_b[addr];
        if (addr == 12) return mdl_ctl;
        return 8'h00;
    endfunction

    task automatic cyc(input logic c, input logic s, input int a, input logic w,
                       input logic r, input int d, input string tag);
        logic [7:0] e;
        @(negedge clk);
        cs_n = c; bank_sel = s; addr = 4'(a); wr_en = w; rd_en = r; wdata = 8'(d);
        #1;
        e = expect_rd();
        n_checks++;
        if (rdata !== e) begin
            n_fail++;
            $display("FAIL %s: addr=%0d sel=%0b rdata=%02h expected=%02h", tag, a, s, rdata, e);
        end
        @(posedge clk);
        if (!c && w) begin
            if (a < 12) begin
                if (mdl_ctl[0]) begin mdl_a[a] = 8'(d); mdl_b[a] = 8'(d); end
                else if (s) mdl_a[a] = 8'(d);
                else mdl_b[a] = 8'(d);
            end else if (a == 12) mdl_ctl = 8'(d);
        end
    endtask

    task automatic dump_all(input string tag);
        for (int i = 0; i < 16; i++) cyc(1'b0, 1'b1, i, 1'b0, 1'b1, 0, tag);
        for (int i = 0; i < 16; i++) cyc(1'b0, 1'b0, i, 1'b0, 1'b1, 0, tag);
    endtask

    initial begin
        #1000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 12; i++) begin mdl_a[i] = 8'h00; mdl_b[i] = 8'h00; end
        mdl_ctl = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        dump_all("R1");
        // R3: fill channel A
        for (int i = 0; i < 12; i++) cyc(1'b0, 1'b1, i, 1'b1, 1'b0, 8'hA0 + i, "R3");
        // R4: fill channel B
        for (int i = 0; i < 12; i++) cyc(1'b0, 1'b0, i, 1'b1, 1'b0, 8'h50 + i, "R4");
        dump_all("R5");
        // R5: single register of A changes alone
        cyc(1'b0, 1'b1, 7, 1'b1, 1'b0, 8'h3C, "R5");
        dump_all("R5");
        // R2: deselected writes and reads
        cyc(1'b1, 1'b1, 3, 1'b1, 1'b1, 8'hFF, "R2");
        cyc(1'b1, 1'b0, 12, 1'b1, 1'b1, 8'h01, "R2");
        dump_all("R2");
        // R9: unmapped addresses
        for (int i = 13; i < 16; i++) cyc(1'b0, i[0], i, 1'b1, 1'b1, 8'hEE, "R9");
        dump_all("R9");
        // R10: rd_en low hides data, read-after-write
        cyc(1'b0, 1'b1, 2, 1'b0, 1'b0, 0, "R10");
        cyc(1'b0, 1'b0, 4, 1'b1, 1'b1, 8'h99, "R10");
        cyc(1'b0, 1'b0, 4, 1'b0, 1'b1, 0, "R10");
        // R6: control write with bank_sel low, read both ways
        cyc(1'b0, 1'b0, 12, 1'b1, 1'b0, 8'h81, "R6");
        cyc(1'b0, 1'b0, 12, 1'b0, 1'b1, 0, "R6");
        cyc(1'b0, 1'b1, 12, 1'b0, 1'b1, 0, "R6");
        dump_all("R6");
        // R7: broadcast writes with either select
        cyc(1'b0, 1'b0, 5, 1'b1, 1'b0, 8'h5A, "R7");
        cyc(1'b0, 1'b1, 11, 1'b1, 1'b0, 8'hC3, "R7");
        cyc(1'b0, 1'b1, 0, 1'b1, 1'b1, 8'h11, "R7");
        // R8: reads still per bank
        dump_all("R8");
        cyc(1'b0, 1'b1, 9, 1'b1, 1'b0, 8'h77, "R8");
        cyc(1'b0, 1'b0, 9, 1'b0, 1'b1, 0, "R8");
        cyc(1'b0, 1'b1, 9, 1'b0, 1'b1, 0, "R8");
        // R9 / R2 with broadcast on
        cyc(1'b0, 1'b1, 14, 1'b1, 1'b0, 8'h42, "R9");
        cyc(1'b1, 1'b0, 6, 1'b1, 1'b0, 8'h42, "R2");
        dump_all("R7");
        // R6: clear broadcast, writes target one bank again
        cyc(1'b0, 1'b1, 12, 1'b1, 1'b0, 8'h00, "R6");
        cyc(1'b0, 1'b1, 1, 1'b1, 1'b0, 8'hD4, "R3");
        cyc(1'b0, 1'b0, 2, 1'b1, 1'b0, 8'hB2, "R4");
        dump_all("R5");
        // R1: reset again clears everything
        @(negedge clk); rst = 1'b1;
        @(posedge clk);
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 12; i++) begin mdl_a[i] = 8'h00; mdl_b[i] = 8'h00; end
        mdl_ctl = 8'h00;
        dump_all("R1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule